// File: doc/BRIEF.md
# Coincident-Decoded Word RAM

This block is a single-port synchronous word memory, 1024 words of 16 bits by default. A full-width address decoder would drive one select line per word. This block does not. It arranges its storage as a square grid and splits the address into two halves. Each half drives a small one-hot decoder of its own, one for the rows and one for the columns. A word responds only where its active row line crosses its active column line. With the default sizes that takes 64 decode lines instead of 1024.

To write, the caller places an address and a data word on the buses and raises the write enable for one clock. To read, the caller places an address and raises the read enable. The word appears on the registered data output one clock later and stays there until the next read. The widths are parameters, and the grid is derived from them.

Top module: `cdram_word_ram`

## Requirements
- R1: A word written at an address with `wr_en` high is returned by a later read of that address, and other contents are unchanged.
- R2: When `rd_en` is high and `wr_en` is low at a rising clock edge, `rd_data` shows the addressed word from that edge onward, so it is valid one cycle after the read is requested.
- R3: While `rd_en` is low, `rd_data` keeps its previous value.
- R4: When `wr_en` and `rd_en` are both high in the same cycle, the write is performed and `rd_data` is not updated.
- R5: The upper half of the address selects the row and the lower half selects the column: address = row * 2^(ADDR_W/2) + column. During any access, exactly one row line and exactly one column line are active.
- R6: When neither enable is high, no decode line is active and no word is altered, whatever is on the address and data buses.
- R7: While `rst_n` is low, `rd_data` is forced to zero.
- R8: A write affects only the word at the crossing of the selected lines. Words that share its row or its column keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| addr | input | ADDR_W | Word address, row half above column half |
| wr_data | input | DATA_W | Word to store |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| rd_data | output | DATA_W | Registered read word |

## Verification
The bench builds the block with its default values, ADDR_W=10 and DATA_W=16. This gives a 32 by 32 grid, so the extreme rows and columns (0 and 31) can be reached with addresses such as 0x01F, 0x3E0 and 0x3FF. A pass along the diagonal touches every row line and every column line once. With these sizes, neighbours that share only a row or only a column can be written and then read back to show that the crossing is selective.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
   // split of an address width into row and column halves
   function automatic int unsigned col_bits(input int unsigned aw);
      return aw / 2;
   endfunction

   function automatic int unsigned row_bits(input int unsigned aw);
      return aw - (aw / 2);
   endfunction
endpackage

// File: rtl/cdram_onehot_dec.sv
module cdram_onehot_dec #(
   parameter int unsigned SEL_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      sel_i,
   input  logic                  en_i,
   output logic [(1<<SEL_W)-1:0] line_o
);
   localparam int unsigned LINES = 1 << SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_w
         $error("cdram_onehot_dec: SEL_W out of range");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         assign line_o[i] = en_i && (sel_i == SEL_W'(i));
      end
   endgenerate

   // R5
   line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> ($countones(line_o) == 1));
   // R6
   line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> (line_o == '0));
endmodule

// File: rtl/cdram_cell_grid.sv
module cdram_cell_grid #(
   parameter int unsigned ROWS   = 32,
   parameter int unsigned COLS   = 32,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROWS-1:0]   row_line,
   input  logic [COLS-1:0]   col_line,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] word_out
);
   localparam int unsigned WORDS = ROWS * COLS;

   logic [DATA_W-1:0] tap  [WORDS];
   logic [WORDS-1:0]  hit;

   genvar r, c;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         for (c = 0; c < COLS; c++) begin : g_col
            logic [DATA_W-1:0] word_q;
            assign hit[r*COLS + c] = row_line[r] & col_line[c];
            always_ff @(posedge clk) begin
               if (wr_en && hit[r*COLS + c]) word_q <= wr_data;
            end
            assign tap[r*COLS + c] = hit[r*COLS + c] ? word_q : '0;
         end
      end
   endgenerate

   always_comb begin
      word_out = '0;
      for (int k = 0; k < WORDS; k++) word_out = word_out | tap[k];
   end

   // R8
   cross_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/cdram_read_reg.sv
module cdram_read_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] rd_data
);
   logic load;
   assign load = rd_en & ~wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_data <= '0;
      else if (load) rd_data <= word_in;
   end

   // R3
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   // R4
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |=> $stable(rd_data));
   // R2
   read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> (rd_data == $past(word_in)));
endmodule

// File: rtl/cdram_word_ram.sv
module cdram_word_ram
   import cdram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned COL_W = col_bits(ADDR_W);
   localparam int unsigned ROW_W = row_bits(ADDR_W);
   localparam int unsigned ROWS  = 1 << ROW_W;
   localparam int unsigned COLS  = 1 << COL_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("cdram_word_ram: ADDR_W must be 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("cdram_word_ram: DATA_W must be positive");
      end
   endgenerate

   logic              access;
   logic [ROWS-1:0]   row_line;
   logic [COLS-1:0]   col_line;
   logic [DATA_W-1:0] grid_word;

   assign access = wr_en | rd_en;

   cdram_onehot_dec #(.SEL_W(ROW_W)) u_row_dec (
      .clk(clk), .rst_n(rst_n),
      .sel_i(addr[ADDR_W-1:COL_W]), .en_i(access), .line_o(row_line));

   cdram_onehot_dec #(.SEL_W(COL_W)) u_col_dec (
      .clk(clk), .rst_n(rst_n),
      .sel_i(addr[COL_W-1:0]), .en_i(access), .line_o(col_line));

   cdram_cell_grid #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_grid (
      .clk(clk), .rst_n(rst_n),
      .row_line(row_line), .col_line(col_line),
      .wr_en(wr_en), .wr_data(wr_data), .word_out(grid_word));

   cdram_read_reg #(.DATA_W(DATA_W)) u_rreg (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .wr_en(wr_en),
      .word_in(grid_word), .rd_data(rd_data));

   // R5
   both_axes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access |-> ($countones(row_line) == 1 && $countones(col_line) == 1));
   // R6
   idle_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !access |-> (grid_word == '0));
endmodule

// File: tb/sim_cdram_word_ram.sv
module sim_cdram_word_ram;
   localparam int AW = 10;
   localparam int DW = 16;
   localparam int VW = 2 + AW + DW + DW;
   localparam int NV = 17;

   // {wr_en, rd_en, addr, wr_data, expected rd_data after the edge}
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'b10, 10'h000, 16'hA5A5, 16'h0000},
      {2'b10, 10'h3FF, 16'h1234, 16'h0000},
      {2'b10, 10'h01F, 16'hBEEF, 16'h0000},
      {2'b10, 10'h3E0, 16'hCAFE, 16'h0000},
      {2'b01, 10'h000, 16'h0000, 16'hA5A5},
      {2'b01, 10'h3FF, 16'h0000, 16'h1234},
      {2'b01, 10'h01F, 16'h0000, 16'hBEEF},
      {2'b01, 10'h3E0, 16'h0000, 16'hCAFE},
      {2'b00, 10'h000, 16'hFFFF, 16'hCAFE},
      {2'b01, 10'h000, 16'h0000, 16'hA5A5},
      {2'b11, 10'h000, 16'h0F0F, 16'hA5A5},
      {2'b01, 10'h000, 16'h0000, 16'h0F0F},
      {2'b10, 10'h001, 16'h7777, 16'h0F0F},
      {2'b10, 10'h020, 16'h8888, 16'h0F0F},
      {2'b01, 10'h000, 16'h0000, 16'h0F0F},
      {2'b01, 10'h001, 16'h0000, 16'h7777},
      {2'b01, 10'h020, 16'h0000, 16'h8888}
   };

   function automatic string req_of(input int i);
      case (i)
         0, 1, 2, 3:  return "R1";
         4, 5, 6, 7:  return "R2";
         8:           return "R3";
         9:           return "R6";
         10, 11:      return "R4";
         default:     return "R8";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   cdram_word_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
      .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data));

   task automatic check(input string req, input logic [DW-1:0] exp);
      total++;
      if (rd_data !== exp) begin
         bad++;
         $display("FAIL %s rd_data=%h expected=%h", req, rd_data, exp);
      end
   endtask

   task automatic step(input logic w, input logic r,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = w; rd_en = r; addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R7: reset state
      check("R7", '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3 -: AW],
              VEC[i][2*DW-1 -: DW]);
         check(req_of(i), VEC[i][DW-1:0]);
      end

      // R5: diagonal covers each row line and each column line once
      for (int k = 0; k < 32; k++)
         step(1'b1, 1'b0, AW'(k * 32 + k), DW'(16'h4000 + k));
      for (int k = 0; k < 32; k++) begin
         step(1'b0, 1'b1, AW'(k * 32 + k), '0);
         check("R5", DW'(16'h4000 + k));
      end

      // R8: words next to a diagonal cell in row and column kept
      step(1'b0, 1'b1, 10'h001, '0);
      check("R8", 16'h7777);

      // R3: several idle cycles with changing buses
      step(1'b0, 1'b0, 10'h3FF, 16'hDEAD);
      step(1'b0, 1'b0, 10'h155, 16'h0101);
      check("R3", 16'h7777);

      // R7: reset again clears the read register
      rst_n = 1'b0;
      #1;
      check("R7", '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule